// File: doc/BRIEF.md
# High-Speed UART Bit-Timing Generator

This block produces the bit timing for a UART transmitter or receiver. A programmable prescaler divides the system clock into a divided-clock enable. A bit timer counts divided periods to mark the end of each bit slot and a sampling instant inside it. There are two modes. Standard mode uses a fixed 16 divided periods per bit and samples in the middle. High-speed mode takes the number of periods per bit and the sampling position from software.

In high-speed mode a 10-bit fraction mask can lengthen individual bit slots of a frame by one divided period each. This lets the average bit time land between whole divisor steps. Software programs the block through a byte-wide write port. The timing takes effect at the next frame-start pulse: every frame-start pulse restarts the counters and takes a fresh copy of the programmed values.

The serial shifter uses `bit_tick` to advance to the next bit and `sample_strobe` to sample the line.

Top module: `hs_baud_gen`

## Requirements
- R1: After reset, both outputs stay low until the first frame start. The reset register values are: divisor 0, mode 0, sample count 0, sample point 0xFF, fraction mask 0.
- R2: Each write with `cfg_we` high stores `cfg_wdata` in the register chosen by `cfg_idx`:
  - 0: divisor bits 7:0
  - 1: divisor bits 15:8
  - 2: mode
  - 3: sample count
  - 4: sample point
  - 5: fraction mask bits 7:0
  - 6: fraction mask bits 9:8, taken from `cfg_wdata[1:0]`

  Index 7 changes nothing.
- R3: With divisor D, divided enables fall on the clock edges D, 2D, 3D, and so on, counted from the edge that samples a frame start. Each output is high for the one cycle after the enable that produces it. A divisor of 0 produces no ticks and no strobes.
- R4: Any mode value other than 3 selects standard mode. In standard mode every bit is 16 divided periods long and the strobe falls on in-bit period index 7. The sample count, sample point and fraction mask are ignored.
- R5: Mode value 3 selects high-speed mode. A bit lasts sample count + 1 divided periods. The strobe falls on in-bit period index equal to the sample point. If that index is never reached within a bit, that bit has no strobe.
- R6: In high-speed mode, a set fraction-mask bit k (for k from 0 to 9) makes bit slot k of the frame one divided period longer. Slots from 10 on are never lengthened.
- R7: A frame start restarts the prescaler, the in-bit counter and the slot counter. If a tick or strobe would have been produced on the edge that samples the frame start, it is suppressed.
- R8: The timing registers are copied only when a frame start is sampled. Writes made during a frame do not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index for the write |
| cfg_wdata | input | 8 | Register write data |
| frame_start | input | 1 | One-cycle pulse that starts a frame |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit slot |
| sample_strobe | output | 1 | One-cycle pulse at the sampling point of a bit |

## Verification
The case where two functions meet in one cycle is a frame start landing exactly on the cycle in which an end-of-bit tick and a sample strobe are both due. The bench sets this up with divisor 1, a 4-period bit and the sample point on the last period, then pulses frame start so that it is sampled on the eighth edge. It passes if both outputs are low in that cycle and the next tick and strobe appear exactly four cycles after the restart. Around this, a sweep over divisor, sample count, sample point and mask compares every cycle against bit boundaries computed arithmetically from the programmed lengths.

// File: rtl/hsbt_pkg.sv
package hsbt_pkg;
  typedef enum logic [2:0] {
    IDX_DIV_LO = 3'd0,
    IDX_DIV_HI = 3'd1,
    IDX_MODE   = 3'd2,
    IDX_SCNT   = 3'd3,
    IDX_SPT    = 3'd4,
    IDX_FLO    = 3'd5,
    IDX_FHI    = 3'd6,
    IDX_NONE   = 3'd7
  } cfg_idx_e;

  localparam int MODE_HS_CODE = 3;
endpackage

// File: rtl/hsbt_regs.sv
module hsbt_regs
  import hsbt_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int FHI_W = 2,
  localparam int DIV_W = 2 * CFG_W,
  localparam int SLOTS = CFG_W + FHI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_idx,
  input  logic [CFG_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_q,
  output logic             hs_q,
  output logic [CFG_W-1:0] scnt_q,
  output logic [CFG_W-1:0] spt_q,
  output logic [SLOTS-1:0] mask_q
);
  logic [CFG_W-1:0] div_lo_q, div_lo_d, div_hi_q, div_hi_d;
  logic [CFG_W-1:0] mode_q, mode_d, scnt_d, spt_d, flo_q, flo_d;
  logic [FHI_W-1:0] fhi_q, fhi_d;

  always_comb begin
    div_lo_d = div_lo_q;
    div_hi_d = div_hi_q;
    mode_d   = mode_q;
    scnt_d   = scnt_q;
    spt_d    = spt_q;
    flo_d    = flo_q;
    fhi_d    = fhi_q;
    if (wr_en) begin
      case (cfg_idx_e'(wr_idx))
        IDX_DIV_LO: div_lo_d = wr_data;
        IDX_DIV_HI: div_hi_d = wr_data;
        IDX_MODE:   mode_d   = wr_data;
        IDX_SCNT:   scnt_d   = wr_data;
        IDX_SPT:    spt_d    = wr_data;
        IDX_FLO:    flo_d    = wr_data;
        IDX_FHI:    fhi_d    = wr_data[FHI_W-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo_q <= '0;
      div_hi_q <= '0;
      mode_q   <= '0;
      scnt_q   <= '0;
      spt_q    <= '1;
      flo_q    <= '0;
      fhi_q    <= '0;
    end else begin
      div_lo_q <= div_lo_d;
      div_hi_q <= div_hi_d;
      mode_q   <= mode_d;
      scnt_q   <= scnt_d;
      spt_q    <= spt_d;
      flo_q    <= flo_d;
      fhi_q    <= fhi_d;
    end
  end

  assign div_q  = {div_hi_q, div_lo_q};
  assign hs_q   = (mode_q == CFG_W'(MODE_HS_CODE));
  assign mask_q = {fhi_q, flo_q};

  // R2: registers change only through a write to a used index
  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_idx == 3'd7) |=> ($stable(div_q) && $stable(hs_q) &&
      $stable(scnt_q) && $stable(spt_q) && $stable(mask_q)));
endmodule

// File: rtl/hsbt_prescale.sv
module hsbt_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             dclk_en
);
  logic [DIV_W-1:0] pre_q, pre_d;
  logic             div_zero, at_end;

  always_comb begin
    div_zero = (div == '0);
    at_end   = (pre_q == div - DIV_W'(1));
    dclk_en  = run && !div_zero && !restart && at_end;
    pre_d    = pre_q;
    if (restart)
      pre_d = '0;
    else if (run && !div_zero)
      pre_d = at_end ? '0 : pre_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3: with a divisor above one, two enables are never adjacent
  p_en_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_en && div > DIV_W'(1)) |=> !dclk_en);
endmodule

// File: rtl/hsbt_bittimer.sv
module hsbt_bittimer #(
  parameter int CFG_W   = 8,
  parameter int SLOTS   = 10,
  parameter int STD_OSR = 16,
  localparam int POS_W   = CFG_W + 1,
  localparam int SLOT_W  = $clog2(SLOTS + 1),
  localparam int STD_LAST = STD_OSR - 1,
  localparam int STD_SPT  = STD_OSR / 2 - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             dclk_en,
  input  logic             hs,
  input  logic [CFG_W-1:0] scnt,
  input  logic [CFG_W-1:0] spt,
  input  logic [SLOTS-1:0] mask,
  output logic             bit_tick,
  output logic             sample_strobe
);
  logic [POS_W-1:0]  pos_q, pos_d, last, spt_eff;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              tick_d, strobe_d, stretch, end_bit, hit;

  always_comb begin
    stretch = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_q == SLOT_W'(i)) stretch = mask[i];
    end
    stretch = stretch && hs;
    last    = (hs ? {1'b0, scnt} : POS_W'(STD_LAST)) + POS_W'(stretch);
    spt_eff = hs ? {1'b0, spt} : POS_W'(STD_SPT);
    end_bit = (pos_q == last);
    hit     = (pos_q == spt_eff);
  end

  always_comb begin
    pos_d    = pos_q;
    slot_d   = slot_q;
    tick_d   = 1'b0;
    strobe_d = 1'b0;
    if (restart) begin
      pos_d  = '0;
      slot_d = '0;
    end else if (dclk_en) begin
      tick_d   = end_bit;
      strobe_d = hit;
      pos_d    = end_bit ? '0 : pos_q + POS_W'(1);
      if (end_bit && slot_q != SLOT_W'(SLOTS)) slot_d = slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q         <= '0;
      slot_q        <= '0;
      bit_tick      <= 1'b0;
      sample_strobe <= 1'b0;
    end else begin
      pos_q         <= pos_d;
      slot_q        <= slot_d;
      bit_tick      <= tick_d;
      sample_strobe <= strobe_d;
    end
  end

  // R7: a restart clears counters and suppresses outputs
  p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!bit_tick && !sample_strobe && pos_q == '0 && slot_q == '0));
  // R3: outputs only follow a divided enable
  p_follow_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick || sample_strobe) |-> $past(dclk_en));
  // R5: in-bit position never passes the end of the current bit
  p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= last);
  // R5: a tick leaves the in-bit counter at the start of the next bit
  p_tick_realign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> pos_q == '0);
  // R6: slot counter saturates past the masked slots
  p_slot_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= SLOT_W'(SLOTS));
endmodule

// File: rtl/hs_baud_gen.sv
module hs_baud_gen #(
  parameter int CFG_W   = 8,
  parameter int FHI_W   = 2,
  parameter int STD_OSR = 16,
  localparam int DIV_W  = 2 * CFG_W,
  localparam int SLOTS  = CFG_W + FHI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_idx,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             frame_start,
  output logic             bit_tick,
  output logic             sample_strobe
);
  logic [DIV_W-1:0] r_div, sh_div_q, sh_div_d;
  logic             r_hs, sh_hs_q, sh_hs_d, run_q, run_d;
  logic [CFG_W-1:0] r_scnt, r_spt, sh_scnt_q, sh_scnt_d, sh_spt_q, sh_spt_d;
  logic [SLOTS-1:0] r_mask, sh_mask_q, sh_mask_d;
  logic             dclk_en;

  hsbt_regs #(.CFG_W(CFG_W), .FHI_W(FHI_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_data(cfg_wdata), .div_q(r_div), .hs_q(r_hs), .scnt_q(r_scnt),
    .spt_q(r_spt), .mask_q(r_mask)
  );

  // Frame-start capture of the timing configuration
  always_comb begin
    run_d     = run_q;
    sh_div_d  = sh_div_q;
    sh_hs_d   = sh_hs_q;
    sh_scnt_d = sh_scnt_q;
    sh_spt_d  = sh_spt_q;
    sh_mask_d = sh_mask_q;
    if (frame_start) begin
      run_d     = 1'b1;
      sh_div_d  = r_div;
      sh_hs_d   = r_hs;
      sh_scnt_d = r_scnt;
      sh_spt_d  = r_spt;
      sh_mask_d = r_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      sh_div_q  <= '0;
      sh_hs_q   <= 1'b0;
      sh_scnt_q <= '0;
      sh_spt_q  <= '1;
      sh_mask_q <= '0;
    end else begin
      run_q     <= run_d;
      sh_div_q  <= sh_div_d;
      sh_hs_q   <= sh_hs_d;
      sh_scnt_q <= sh_scnt_d;
      sh_spt_q  <= sh_spt_d;
      sh_mask_q <= sh_mask_d;
    end
  end

  hsbt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(frame_start), .run(run_q),
    .div(sh_div_q), .dclk_en(dclk_en)
  );

  hsbt_bittimer #(.CFG_W(CFG_W), .SLOTS(SLOTS), .STD_OSR(STD_OSR)) u_bit (
    .clk(clk), .rst_n(rst_n), .restart(frame_start), .dclk_en(dclk_en),
    .hs(sh_hs_q), .scnt(sh_scnt_q), .spt(sh_spt_q), .mask(sh_mask_q),
    .bit_tick(bit_tick), .sample_strobe(sample_strobe)
  );

  // R1: nothing is produced before the first frame start
  p_idle_before_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!bit_tick && !sample_strobe));
  // R3: a zero divisor keeps both outputs low
  p_zero_div_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_div_q == '0) |=> (!bit_tick && !sample_strobe));
  // R8: captured timing holds between frame starts
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(sh_div_q) && $stable(sh_hs_q) &&
      $stable(sh_scnt_q) && $stable(sh_spt_q) && $stable(sh_mask_q)));
endmodule

// File: tb/hs_baud_gen_test.sv
module hs_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_wdata = '0;
  logic       frame_start = 1'b0;
  logic       bit_tick, sample_strobe;

  int checks = 0;
  int bad = 0;
  int m_div, m_hs, m_scnt, m_spt, m_mask;

  always #4 clk = ~clk;

  hs_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start),
    .bit_tick(bit_tick), .sample_strobe(sample_strobe)
  );

  task automatic check(input string req, input bit ok, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input int d, input int mode, input int scnt,
                         input int spt, input int mask);
    wr(0, d & 255); wr(1, (d >> 8) & 255); wr(2, mode);
    wr(3, scnt); wr(4, spt); wr(5, mask & 255); wr(6, (mask >> 8) & 3);
    m_div = d; m_hs = (mode == 3) ? 1 : 0; m_scnt = scnt; m_spt = spt; m_mask = mask;
  endtask

  // Outputs expected after the m-th divided enable, from bit lengths (R4 R5 R6)
  function automatic void expect_at(input int m, output bit t, output bit s);
    int cum = 0;
    int spte = (m_hs != 0) ? m_spt : 7;
    t = 1'b0; s = 1'b0;
    for (int b = 0; b < 100000; b++) begin
      int len = (m_hs != 0) ? m_scnt + 1 : 16;
      if (m_hs != 0 && b < 10 && ((m_mask >> b) & 1) == 1) len++;
      if (m <= cum + len) begin
        t = (m == cum + len);
        s = ((m - 1 - cum) == spte);
        return;
      end
      cum += len;
    end
  endfunction

  task automatic run_frame(input string req, input int ncyc, input int mid_k,
                           input int mid_idx, input int mid_data);
    int errs = 0, first_k = -1, fa = 0, fe = 0;
    bit t, s;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    if (bit_tick || sample_strobe) begin
      errs++; first_k = 0; fa = {bit_tick, sample_strobe}; fe = 0;
    end
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      t = 1'b0; s = 1'b0;
      if (m_div != 0 && (k % m_div) == 0) expect_at(k / m_div, t, s);
      if ({bit_tick, sample_strobe} != {t, s}) begin
        if (errs == 0) begin
          first_k = k; fa = {bit_tick, sample_strobe}; fe = {t, s};
        end
        errs++;
      end
      if (k == mid_k) begin
        cfg_we = 1'b1; cfg_idx = 3'(mid_idx); cfg_wdata = 8'(mid_data);
      end
    end
    cfg_we = 1'b0;
    check(req, errs == 0, $sformatf("cycle %0d {tick,strobe}", first_k), fa, fe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int quiet = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: no output before any frame start
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bit_tick || sample_strobe) quiet++;
    end
    check("R1 idle after reset", quiet == 0, "active cycles", quiet, 0);
    // R1: reset divisor is 0, so a frame produces nothing
    m_div = 0; m_hs = 0; m_scnt = 0; m_spt = 255; m_mask = 0;
    run_frame("R1 reset divisor", 200, -1, 0, 0);
    // R1: reset sample count 0 and point 0xFF: one-period bits, no strobe
    wr(0, 1); wr(2, 3);
    m_div = 1; m_hs = 1;
    run_frame("R1 reset count/point", 40, -1, 0, 0);

    // R4: standard mode ignores count, point and mask
    set_cfg(2, 0, 5, 1, 'h3FF);
    run_frame("R4 standard mode 0", 2 * 16 * 4 + 3, -1, 0, 0);
    set_cfg(1, 1, 9, 2, 'h155);
    run_frame("R4 mode 1 is standard", 16 * 5 + 3, -1, 0, 0);

    // R2: index 7 write leaves timing unchanged
    wr(7, 'hAB);
    run_frame("R2 unused index ignored", 16 * 5 + 3, -1, 0, 0);

    // R3: divisor high byte and zero divisor
    set_cfg(258, 3, 1, 0, 0);
    run_frame("R3 divisor high byte", 258 * 2 * 3 + 3, -1, 0, 0);
    set_cfg(0, 3, 3, 1, 'h3FF);
    run_frame("R3 zero divisor", 200, -1, 0, 0);

    // R5 R6 sweep over divisor, count, point and mask
    for (int d = 1; d <= 3; d++) begin
      for (int si = 0; si < 3; si++) begin
        int sc = (si == 0) ? 2 : (si == 1) ? 3 : 6;
        for (int pi = 0; pi < 4; pi++) begin
          int sp = (pi == 0) ? 0 : (pi == 1) ? (sc >> 1) : (pi == 2) ? sc : sc + 1;
          for (int mi = 0; mi < 4; mi++) begin
            int mk = (mi == 0) ? 0 : (mi == 1) ? 'h3FF : (mi == 2) ? 'h2A5 : 'h200;
            set_cfg(d, 3, sc, sp, mk);
            run_frame($sformatf("R5 R6 d=%0d cnt=%0d pt=%0d mask=%03h", d, sc, sp, mk),
                      d * (sc + 2) * 12 + 3, -1, 0, 0);
          end
        end
      end
    end

    // R8: mid-frame write does not affect running frame, next frame uses it
    set_cfg(1, 3, 4, 2, 0);
    run_frame("R8 mid-frame write held off", 60, 10, 3, 1);
    m_scnt = 1;
    run_frame("R8 next frame uses new count", 20, -1, 0, 0);

    // R7: frame start on the cycle a tick and strobe are due
    set_cfg(1, 3, 3, 3, 0);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    repeat (7) @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check("R7 collision tick suppressed", bit_tick == 1'b0, "tick", bit_tick, 0);
    check("R7 collision strobe suppressed", sample_strobe == 1'b0, "strobe", sample_strobe, 0);
    repeat (3) @(negedge clk);
    check("R7 no early tick after restart", bit_tick == 1'b0, "tick", bit_tick, 0);
    @(negedge clk);
    check("R7 tick realigned after restart", bit_tick == 1'b1, "tick", bit_tick, 1);
    check("R7 strobe realigned after restart", sample_strobe == 1'b1, "strobe", sample_strobe, 1);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule